// File: doc/BRIEF.md
# Clock Multiplier Change Sequencer

This block holds the active multiplier code that a clock generator uses and decides when a newly requested code reaches the generator. Software writes a multiplier code, an apply-now flag and a settling-time code through one write port. With the apply-now flag set, a valid code takes effect on the next clock. With it clear, the code is parked as pending and is loaded only when the chip enters standby.

Standby is driven by two request inputs. An entry request stops the clock and commits any pending code. A wake request starts a digital down-count whose length comes from the stored settling code. When the count expires, the block drops its clock-stop output and gives a one-cycle ready pulse. The oscillator, the loop filter and the divider that follows lie outside this block. It only produces the selection code and the stop/resume timing.

Top module: `clkmul_seq`

## Requirements
- R1: Synchronous active-low reset sets the active code to 00 (×1), clears any pending code, drives clk_stop and ready low and selects settling code 0.
- R2: Multiplier codes are 00 = ×1, 01 = ×2, 10 = ×4. A write carrying code 11 leaves both the active and the pending code unchanged. The mode and settling fields of that write are still stored.
- R3: A write with apply-now = 1 and a valid code shows that code on mult_code in the cycle after the write, and any pending code is discarded.
- R4: A write with apply-now = 0 and a valid code leaves mult_code unchanged while running. The code appears on mult_code in the cycle after the standby entry request is accepted.
- R5: An entry request while running raises clk_stop in the next cycle. clk_stop stays high while stopped and throughout settling.
- R6: The settling count lasts N = 2^(BASE_LOG2 + min(code, SAT_CODE)) clock edges. The count runs from the edge that samples the wake request while stopped to the edge that raises ready. With the defaults (6, 11), code 0 gives 64 cycles, each higher code doubles the count, and codes 11 to 15 all give 131072.
- R7: ready is high for exactly one cycle when the count expires, and clk_stop falls in that same cycle. At all other times ready is low.
- R8: A wake request during settling does not restart or shorten the count. An entry request while stopped or settling has no effect. A wake request while running has no effect.
- R9: A standby entry and exit with no pending code still runs the full settling count and leaves mult_code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the three configuration fields |
| cfg_mult | input | 2 | Requested multiplier code (00/01/10, 11 reserved) |
| cfg_now | input | 1 | 1 = apply on write, 0 = defer until standby entry |
| cfg_settle | input | 4 | Settling-time code |
| sby_enter | input | 1 | Request to enter standby |
| sby_exit | input | 1 | Request to leave standby |
| mult_code | output | 2 | Active multiplier code to the clock generator |
| clk_stop | output | 1 | High while the clock is held stopped or settling |
| ready | output | 1 | One-cycle pulse when operation resumes |

## Verification
The bench measures the settling length edge by edge for several codes, including codes above the saturation point. A timer with an off-by-one or a missing clamp would give a different count. During the count it sends stray wake and entry requests; a sequencer that restarted the timer would take longer. It writes the reserved code in both modes, and a deferred code is later committed. A design that stored code 11, or that applied a deferred code before standby, would show the wrong value on mult_code. It also asserts reset in the middle of settling, which a design must clear fully without a stray ready pulse.

// File: rtl/clkmul_pkg.sv
// Shared encodings for the clock multiplier change sequencer.
package clkmul_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_e;

    localparam logic [1:0] MUL_X1   = 2'b00;
    localparam logic [1:0] MUL_X2   = 2'b01;
    localparam logic [1:0] MUL_X4   = 2'b10;
    localparam logic [1:0] MUL_RSVD = 2'b11;

    function automatic logic mul_code_ok(input logic [1:0] c);
        return c != MUL_RSVD;
    endfunction

endpackage

// File: rtl/clkmul_mult_reg.sv
// Holds the active and pending multiplier codes.
// Apply-now writes go straight to the active code. Deferred writes wait
// in a pending slot until commit, which is the accepted standby entry.
// Reserved code writes are dropped. Assumes commit is a one-cycle pulse.
module clkmul_mult_reg
    import clkmul_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_now,
    input  logic [1:0] wr_code,
    input  logic       commit,
    output logic [1:0] active
);

    logic [1:0] act_q;
    logic [1:0] pend_q;
    logic       pend_vld_q;
    logic       wr_ok;

    // Decide whether a write carries a legal code.
    always_comb begin
        wr_ok = wr_en && mul_code_ok(wr_code);
    end

    // Update the active and pending codes; a write in the same cycle overrides commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q      <= MUL_X1;
            pend_q     <= MUL_X1;
            pend_vld_q <= 1'b0;
        end else begin
            if (commit && pend_vld_q) begin
                act_q      <= pend_q;
                pend_vld_q <= 1'b0;
            end
            if (wr_ok) begin
                if (wr_now) begin
                    act_q      <= wr_code;
                    pend_vld_q <= 1'b0;
                end else begin
                    pend_q     <= wr_code;
                    pend_vld_q <= 1'b1;
                end
            end
        end
    end

    assign active = act_q;

    // R2: a reserved code never disturbs the active code
    a_r2_rsvd_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_code == MUL_RSVD && !commit) |=> $stable(act_q));

    // R3: apply-now write lands one cycle later
    a_r3_now_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_now && wr_code != MUL_RSVD) |=> act_q == $past(wr_code));

    // R4: without commit or apply-now write the active code holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_now) && !commit) |=> $stable(act_q));

endmodule

// File: rtl/clkmul_settle_timer.sv
// Settling down-counter. Stores the settling code on each write. On load
// it arms with 2^(BASE_LOG2+min(code,SAT_CODE))-1 and counts down to zero.
// done is high for the single cycle in which an armed count sits at zero.
// Assumes SAT_CODE <= 15.
module clkmul_settle_timer #(
    parameter int BASE_LOG2 = 6,
    parameter int SAT_CODE  = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [3:0] sel_in,
    input  logic       load,
    output logic       done
);

    localparam int CW = BASE_LOG2 + SAT_CODE;

    logic [3:0]    sel_q;
    logic [3:0]    eff;
    logic [CW-1:0] load_val;
    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // Clamp the code and derive the count start value.
    always_comb begin
        eff      = (sel_q > 4'(SAT_CODE)) ? 4'(SAT_CODE) : sel_q;
        load_val = ~({CW{1'b1}} << (BASE_LOG2 + int'(eff)));
    end

    // Hold the settling code and run the down-count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            if (sel_wr) sel_q <= sel_in;
            if (load) begin
                cnt_q  <= load_val;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (cnt_q == '0) busy_q <= 1'b0;
                else             cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    assign done = busy_q && (cnt_q == '0);

    // R6: every armed cycle away from zero steps down by exactly one
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0 && !load) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

    // R6: a load arms the counter with the decoded length
    a_r6_arm: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy_q && cnt_q == $past(load_val)));

    // R7: expiry disarms the counter
    a_r7_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> !busy_q);

endmodule

// File: rtl/clkmul_ctrl.sv
// Standby sequencer: running, stopped, settling. Entry is taken only while
// running (it also commits the pending code). Wake is taken only while
// stopped (it arms the timer). Timer expiry returns to running with a
// one-cycle ready pulse. Assumes done comes from the timer armed by load.
module clkmul_ctrl
    import clkmul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sby_enter,
    input  logic sby_exit,
    input  logic done,
    output logic load,
    output logic commit,
    output logic clk_stop,
    output logic ready
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       ready_q;

    // Next-state and strobe decode.
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        load    = 1'b0;
        unique case (state_q)
            ST_RUN: if (sby_enter) begin
                state_d = ST_STOP;
                commit  = 1'b1;
            end
            ST_STOP: if (sby_exit) begin
                state_d = ST_SETTLE;
                load    = 1'b1;
            end
            ST_SETTLE: if (done) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // Register the state and the resume pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ready_q <= (state_q == ST_SETTLE) && done;
        end
    end

    assign clk_stop = (state_q != ST_RUN);
    assign ready    = ready_q;

    // R7: ready is a single-cycle pulse
    a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R7: ready only follows settling and coincides with the clock running
    a_r7_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ($past(state_q) == ST_SETTLE && !clk_stop));

    // R8: settling holds until the timer expires, whatever the requests
    a_r8_settle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !done) |=> state_q == ST_SETTLE);

    // R5: stopped clock stays stopped until a wake request
    a_r5_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !sby_exit) |=> (state_q == ST_STOP && clk_stop));

    // R8: a wake request while running changes nothing
    a_r8_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !sby_enter) |=> (!clk_stop && !ready));

endmodule

// File: rtl/clkmul_seq.sv
// Top of the clock multiplier change sequencer: code register, standby
// sequencer and settling timer. One write strobe captures the multiplier
// code, the apply-now flag and the settling code together.
module clkmul_seq #(
    parameter int BASE_LOG2 = 6,
    parameter int SAT_CODE  = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_mult,
    input  logic       cfg_now,
    input  logic [3:0] cfg_settle,
    input  logic       sby_enter,
    input  logic       sby_exit,
    output logic [1:0] mult_code,
    output logic       clk_stop,
    output logic       ready
);

    logic load;
    logic commit;
    logic done;

    clkmul_mult_reg u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_now  (cfg_now),
        .wr_code (cfg_mult),
        .commit  (commit),
        .active  (mult_code)
    );

    clkmul_settle_timer #(
        .BASE_LOG2 (BASE_LOG2),
        .SAT_CODE  (SAT_CODE)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_wr (cfg_wr),
        .sel_in (cfg_settle),
        .load   (load),
        .done   (done)
    );

    clkmul_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sby_enter (sby_enter),
        .sby_exit  (sby_exit),
        .done      (done),
        .load      (load),
        .commit    (commit),
        .clk_stop  (clk_stop),
        .ready     (ready)
    );

endmodule

// File: tb/clkmul_seq_tb.sv
module clkmul_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TB_BASE    = 2;
    localparam int TB_SAT     = 3;
    localparam int NVEC       = 7;

    // Per vector: apply-now, code, settle code, code after write, code after entry, settle cycles
    localparam int V_NOW [NVEC] = '{1, 0, 0, 1, 0, 1, 0};
    localparam int V_CODE[NVEC] = '{1, 2, 3, 0, 1, 3, 0};
    localparam int V_SEL [NVEC] = '{0, 1, 2, 3, 9, 0, 15};
    localparam int V_WEXP[NVEC] = '{1, 1, 2, 0, 0, 1, 1};
    localparam int V_SEXP[NVEC] = '{1, 2, 2, 0, 1, 1, 0};
    localparam int V_N   [NVEC] = '{4, 8, 16, 32, 32, 4, 32};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_mult = 2'b00;
    logic       cfg_now = 1'b0;
    logic [3:0] cfg_settle = 4'd0;
    logic       sby_enter = 1'b0;
    logic       sby_exit = 1'b0;
    logic [1:0] mult_code;
    logic       clk_stop;
    logic       ready;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkmul_seq #(.BASE_LOG2(TB_BASE), .SAT_CODE(TB_SAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mult(cfg_mult),
        .cfg_now(cfg_now), .cfg_settle(cfg_settle), .sby_enter(sby_enter),
        .sby_exit(sby_exit), .mult_code(mult_code), .clk_stop(clk_stop),
        .ready(ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input int now, input int code, input int sel);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_now = now[0]; cfg_mult = code[1:0]; cfg_settle = sel[3:0];
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Enter standby, wait, wake, measure settle edges; optionally poke requests mid-count.
    task automatic standby_cycle(input int exp_code, input int exp_n, input bit poke);
        int k;
        @(negedge clk);
        sby_enter = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sby_enter = 1'b0;
        chk("R5 clk_stop after entry", clk_stop, 1);
        chk("R4 code after entry", mult_code, exp_code);
        repeat (3) @(negedge clk);
        chk("R5 still stopped", clk_stop, 1);
        chk("R7 ready low while stopped", ready, 0);
        sby_exit = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sby_exit = 1'b0;
        k = 0;
        while (k < 1000) begin
            @(posedge clk);
            @(negedge clk);
            k++;
            if (ready) break;
            if (!clk_stop) begin
                chk("R5 clk_stop during settle", 0, 1);
                break;
            end
            if (poke && k == 2) begin sby_exit = 1'b1; sby_enter = 1'b1; end
            else begin sby_exit = 1'b0; sby_enter = 1'b0; end
        end
        sby_exit = 1'b0; sby_enter = 1'b0;
        chk(poke ? "R8 R6 settle length with stray requests" : "R6 settle length", k, exp_n);
        chk("R7 clk_stop falls with ready", clk_stop, 0);
        chk("R9 code kept through standby", mult_code, exp_code);
        @(negedge clk);
        chk("R7 ready one cycle", ready, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset code", mult_code, 0);
        chk("R1 reset clk_stop", clk_stop, 0);
        chk("R1 reset ready", ready, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: wake request while running is ignored
        sby_exit = 1'b1;
        @(negedge clk);
        sby_exit = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 wake while running clk_stop", clk_stop, 0);
        chk("R8 wake while running ready", ready, 0);

        // R9: no pending code, settle code 0 from reset
        standby_cycle(0, 4, 1'b0);

        // Vector walk: R2 R3 R4 R6 R9
        for (int i = 0; i < NVEC; i++) begin
            do_write(V_NOW[i], V_CODE[i], V_SEL[i]);
            chk("R3 R4 R2 code after write", mult_code, V_WEXP[i]);
            standby_cycle(V_SEXP[i], V_N[i], (i % 2) == 1);
        end

        // R4: deferred code replaced by apply-now write is dropped (R3)
        do_write(0, 2, 0);
        chk("R4 deferred not applied", mult_code, 0);
        do_write(1, 1, 0);
        chk("R3 apply-now", mult_code, 1);
        standby_cycle(1, 4, 1'b0);

        // R2: reserved deferred write keeps earlier pending code
        do_write(0, 2, 1);
        do_write(0, 3, 1);
        chk("R2 reserved deferred", mult_code, 1);
        standby_cycle(2, 8, 1'b1);

        // R1: reset in the middle of settling
        @(negedge clk);
        sby_enter = 1'b1;
        @(negedge clk);
        sby_enter = 1'b0; sby_exit = 1'b1;
        @(negedge clk);
        sby_exit = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid-settle reset clk_stop", clk_stop, 0);
        chk("R1 mid-settle reset code", mult_code, 0);
        repeat (20) begin
            @(negedge clk);
            if (ready) chk("R1 no ready after reset", 1, 0);
        end
        chk("R1 stays running", clk_stop, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule